// File: doc/BRIEF.md
# Variable-Length Instruction Parser

This block sits at the front of an instruction decoder for a byte-coded CISC machine. It takes an instruction stream one byte per handshake. For each instruction it finds the operand count from the opcode and walks the operand specifiers. Each specifier may carry an index prefix, a short literal, a register form or a trailing displacement. Some opcodes also take a fixed-length branch displacement after their operands. When the last byte of an instruction has been taken, the parser presents one record. The record holds the opcode, the basic operand count, every specifier byte, the assembled displacements, the branch displacement and the total byte length.

Opcodes that the hardware leaves to a software emulation routine produce a record with a trap flag. Opcodes that are unused produce a record with an illegal-opcode flag. Both kinds consume only the opcode byte. A malformed base after an index prefix ends the instruction early and raises a specifier-error flag.

On the input side a byte is taken on every clock edge where `in_valid` and `in_ready` are both high. On the output side a record is taken on every edge where `out_valid` and `out_ready` are both high. While a record waits for the consumer, `in_ready` stays low and the record holds still, so back-pressure stalls the byte source without losing anything. After the record is accepted, the next byte is read as an opcode.

Top module: `vlp_parser`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it falls, `out_valid` is low and `in_ready` is high. The first byte taken afterwards is treated as an opcode.
- R2: While `out_valid` is high, `in_ready` is low, and every record field stays unchanged until the cycle where `out_ready` is high. On the clock edge where the record is accepted, `out_valid` falls.
- R3: An opcode with no operands and no branch field (0x10) gives a record with length 1, operand count 0, specifier count 0 and all flags low.
- R4: The operand count comes from the opcode. 0x09 takes 2 operands, 0x18 takes 3, and both 0x2E and 0x3E take 4. `out_nops` reports this count.
- R5: In a specifier byte, bits 7:4 are the mode and bits 3:0 are the register. Modes 0x0–0x3 (short literals) and modes 0x5–0x9 (register forms) add no bytes after the specifier. Their displacement slot reads 0.
- R6: Modes 0xA/0xB take 1 displacement byte, modes 0xC/0xD take 2, and modes 0xE/0xF take 4. The bytes are assembled least-significant first, sign-extended to 32 bits, and placed in the displacement slot of that specifier.
- R7: Mode 0x4 is an index prefix. It takes a specifier slot of its own and counts in `out_nspec` and `out_len`. It does not count as an operand, and the specifier that follows it supplies the base.
- R8: If the specifier after an index prefix has mode 0x0–0x5, the instruction ends at that byte. The record then has `out_illspec` high, a length that includes the offending byte, and that byte stored in its slot. The next byte taken is an opcode.
- R9: The opcodes 0x05, 0x15, 0x25, 0x35, 0x45, 0x55, 0x76, 0x77, 0x86, 0x87, 0x97, 0xA6, 0xC6, 0xC7, 0xD6, 0xD7, 0xE6, 0xE7, 0xF6 and 0xF7 give a record with `out_trap` high, length 1, operand count 0 and specifier count 0.
- R10: Unused opcodes, among them 0x02, 0x04 and 0xFF, give a record with `out_illop` high, length 1, operand count 0 and specifier count 0. The next byte is an opcode.
- R11: Opcode 0x11 is followed by a 1-byte branch displacement and 0x13 by a 2-byte one, with no operands. Opcode 0x0E takes 2 operands and then a 2-byte branch displacement. The branch bytes are assembled least-significant first, sign-extended into `out_br_disp`, and counted in the length.
- R12: Specifier slot k appears in `out_spec[8k+7:8k]` and its displacement in `out_disp[32k+31:32k]`, with slots filled in stream order from 0. `out_nspec` gives the number of slots used. At most one of `out_trap`, `out_illop` and `out_illspec` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A stream byte is offered |
| in_ready | output | 1 | The parser can take a byte |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | A record is presented |
| out_ready | input | 1 | The consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_nops | output | 3 | Basic operand count (0 on trap or illegal opcode) |
| out_nspec | output | CNT_W (4) | Number of specifier slots used |
| out_spec | output | 8*MAX_SPEC (64) | Specifier bytes, slot k at bits 8k+7:8k |
| out_disp | output | 32*MAX_SPEC (256) | Sign-extended displacement per slot |
| out_br_disp | output | 32 | Sign-extended branch displacement |
| out_len | output | LEN_W (5) | Instruction length in bytes |
| out_trap | output | 1 | Opcode must be emulated in software |
| out_illop | output | 1 | Opcode is unused |
| out_illspec | output | 1 | Invalid base after an index prefix |

## Verification
The parser's state is its position inside the instruction: operands left, displacement bytes left, and whether a base is pending. A wrong count or length misaligns every later byte. The error therefore shows in the record of the instruction where it happens, as a wrong length or slot content. It also shows in the next record, whose opcode becomes a byte taken from the middle of the stream. The directed streams are chosen so that every displacement width, index chain, branch field and abort path is followed at once by a known opcode. Any slip is therefore visible within one instruction.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

  localparam int NOPS_W = 3;
  localparam int DISP_W = 32;

  typedef enum logic [2:0] {
    ST_OP,
    ST_SPEC,
    ST_DISP,
    ST_BR,
    ST_OUT
  } vlp_state_t;

  typedef struct packed {
    logic              legal;
    logic              trap;
    logic [NOPS_W-1:0] nops;
    logic [2:0]        brlen;
  } op_info_t;

endpackage

// File: rtl/vlp_opcode_rom.sv
module vlp_opcode_rom
  import vlp_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);

  logic [3:0] r;
  logic [3:0] c;

  always_comb begin
    r    = op[7:4];
    c    = op[3:0];
    info = '0;
    case (c)
      4'h0: begin
        if (r <= 4'h4 || r == 4'h6 || r == 4'h7) info.legal = 1'b1;
        else if (r == 4'hC || r == 4'hD) begin info.legal = 1'b1; info.nops = 3'd3; end
        else if (r >= 4'hE) begin info.legal = 1'b1; info.nops = 3'd2; end
      end
      4'h1: begin
        if (r == 4'h7) begin info.legal = 1'b1; info.nops = 3'd1; end
        else if (r != 4'h0 && r != 4'h6) begin info.legal = 1'b1; info.brlen = 3'd1; end
      end
      4'h2: begin
        if (r == 4'h8 || r == 4'h9) begin info.legal = 1'b1; info.nops = 3'd2; end
        else if (r == 4'hC || r == 4'hD) begin info.legal = 1'b1; info.nops = 3'd3; end
      end
      4'h3: begin
        if (r == 4'h1) begin info.legal = 1'b1; info.brlen = 3'd2; end
        else if (r == 4'h2 || r == 4'h3 || r == 4'hC) begin info.legal = 1'b1; info.nops = 3'd2; end
      end
      4'h5: begin
        if (r <= 4'h5) begin info.legal = 1'b1; info.trap = 1'b1; end
      end
      4'h6, 4'h7: begin
        if (r == 4'h7 || r == 4'h8 || r >= 4'hC || (c == 4'h6 ? r == 4'hA : r == 4'h9)) begin
          info.legal = 1'b1;
          info.trap  = 1'b1;
        end else if (r <= 4'h5) begin
          info.legal = 1'b1;
          info.nops  = (r == 4'h4) ? 3'd2 : 3'd1;
        end else if (r == 4'hB || (c == 4'h7 && r == 4'h6)) begin
          info.legal = 1'b1;
        end
      end
      4'h8, 4'hA, 4'hC: begin
        info.legal = 1'b1;
        if (r <= 4'h3 || (r >= 4'h8 && r <= 4'hD)) info.nops = 3'd2 + {2'b00, r[0]};
        else if (r == 4'h4 || r == 4'h5) info.nops = (c == 4'hC) ? 3'd2 + {2'b00, r[0]} : 3'd3;
        else if (r == 4'h6 || r == 4'h7) begin
          if (c == 4'hC) info.nops = 3'd2 + {2'b00, r[0]};
          else info.legal = 1'b0;
        end
        else if (r == 4'hE) info.nops = 3'd2;
        else begin
          if (c == 4'hA) info.legal = 1'b0;
          else if (c == 4'hC) info.nops = 3'd3;
        end
      end
      4'h9, 4'hB, 4'hD: begin
        info.legal = 1'b1;
        info.nops  = 3'd2;
        if ((r >= 4'h4 && r <= 4'h7) || r == 4'hD || r == 4'hF) info.nops = 3'd1;
        if (c == 4'hB && r >= 4'h8 && r <= 4'hB) info.nops = 3'd1;
        if (c == 4'hD && r == 4'hC) info.nops = 3'd1;
      end
      4'hE: begin
        if (r <= 4'h1) begin info.legal = 1'b1; info.nops = 3'd2; info.brlen = 3'd2; end
        else if (r <= 4'h3) begin info.legal = 1'b1; info.nops = 3'd4; end
        else if (r <= 4'h5) begin info.legal = 1'b1; info.nops = 3'd3; end
        else if ((r >= 4'h8 && r <= 4'hB) || r == 4'hF) begin info.legal = 1'b1; info.nops = 3'd2; end
        else if (r == 4'hC) begin info.legal = 1'b1; info.nops = 3'd1; end
      end
      4'hF: begin
        if (r == 4'h2 || r == 4'h3) begin info.legal = 1'b1; info.nops = 3'd3; info.brlen = 3'd2; end
        else if (r == 4'h5) begin info.legal = 1'b1; info.nops = 3'd2; info.brlen = 3'd2; end
        else if (r == 4'h6 || r == 4'h7 || r == 4'hB) begin info.legal = 1'b1; info.nops = 3'd2; end
        else if (r == 4'hC) begin info.legal = 1'b1; info.nops = 3'd1; end
      end
      default: info = '0;
    endcase
  end

endmodule

// File: rtl/vlp_spec_class.sv
module vlp_spec_class (
  input  logic [7:0] spec,
  output logic       is_lit,
  output logic       is_idx,
  output logic       is_reg,
  output logic [2:0] dlen
);

  logic [3:0] mode;

  always_comb begin
    mode   = spec[7:4];
    is_lit = (mode <= 4'h3);
    is_idx = (mode == 4'h4);
    is_reg = (mode == 4'h5);
    case (mode)
      4'hA, 4'hB: dlen = 3'd1;
      4'hC, 4'hD: dlen = 3'd2;
      4'hE, 4'hF: dlen = 3'd4;
      default:    dlen = 3'd0;
    endcase
  end

endmodule

// File: rtl/vlp_disp_acc.sv
module vlp_disp_acc
  import vlp_pkg::*;
(
  input  logic [DISP_W-1:0] acc,
  input  logic [7:0]        data,
  input  logic [1:0]        pos,
  input  logic [2:0]        nbytes,
  output logic [DISP_W-1:0] acc_nxt,
  output logic [DISP_W-1:0] value
);

  always_comb begin
    acc_nxt = acc | (DISP_W'(data) << {pos, 3'b000});
    case (nbytes)
      3'd1:    value = {{(DISP_W-8){acc_nxt[7]}}, acc_nxt[7:0]};
      3'd2:    value = {{(DISP_W-16){acc_nxt[15]}}, acc_nxt[15:0]};
      default: value = acc_nxt;
    endcase
  end

endmodule

// File: rtl/vlp_parser.sv
module vlp_parser
  import vlp_pkg::*;
#(
  parameter int  MAX_OPS  = 4,
  localparam int MAX_SPEC = 2 * MAX_OPS,
  localparam int SLOT_W   = $clog2(MAX_SPEC),
  localparam int CNT_W    = $clog2(MAX_SPEC + 1),
  localparam int LEN_W    = $clog2(MAX_SPEC + 4 * MAX_OPS + 6)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_byte,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_opcode,
  output logic [NOPS_W-1:0]          out_nops,
  output logic [CNT_W-1:0]           out_nspec,
  output logic [8*MAX_SPEC-1:0]      out_spec,
  output logic [DISP_W*MAX_SPEC-1:0] out_disp,
  output logic [DISP_W-1:0]          out_br_disp,
  output logic [LEN_W-1:0]           out_len,
  output logic                       out_trap,
  output logic                       out_illop,
  output logic                       out_illspec
);

  vlp_state_t        st, fin_st;
  op_info_t          info;
  logic [7:0]        opc_r;
  logic [NOPS_W-1:0] nops_r, ops_left;
  logic [CNT_W-1:0]  idx, nspec_r;
  logic [SLOT_W-1:0] slot;
  logic [LEN_W-1:0]  len_r;
  logic [2:0]        brlen_r, dtot, disp_left;
  logic [1:0]        pos;
  logic [DISP_W-1:0] acc, acc_nxt, dval, br_r;
  logic              need_base, trap_r, illop_r, illspec_r;
  logic              take, bad_base, last_op;
  logic              c_lit, c_idx, c_reg;
  logic [2:0]        c_dlen;
  logic [7:0]        spec_r [MAX_SPEC];
  logic [DISP_W-1:0] disp_r [MAX_SPEC];

  vlp_opcode_rom u_rom (.op(in_byte), .info(info));

  vlp_spec_class u_cls (
    .spec(in_byte), .is_lit(c_lit), .is_idx(c_idx), .is_reg(c_reg), .dlen(c_dlen)
  );

  vlp_disp_acc u_acc (
    .acc(acc), .data(in_byte), .pos(pos), .nbytes(dtot), .acc_nxt(acc_nxt), .value(dval)
  );

  always_comb begin
    in_ready = (st != ST_OUT);
    take     = in_valid && in_ready;
    slot     = idx[SLOT_W-1:0];
    bad_base = need_base && (c_lit || c_idx || c_reg);
    last_op  = (ops_left == NOPS_W'(1));
    if (!last_op)            fin_st = ST_SPEC;
    else if (brlen_r != '0)  fin_st = ST_BR;
    else                     fin_st = ST_OUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OP;
      opc_r     <= '0;
      nops_r    <= '0;
      ops_left  <= '0;
      idx       <= '0;
      nspec_r   <= '0;
      len_r     <= '0;
      brlen_r   <= '0;
      dtot      <= '0;
      disp_left <= '0;
      pos       <= '0;
      acc       <= '0;
      br_r      <= '0;
      need_base <= 1'b0;
      trap_r    <= 1'b0;
      illop_r   <= 1'b0;
      illspec_r <= 1'b0;
      for (int k = 0; k < MAX_SPEC; k++) begin
        spec_r[k] <= '0;
        disp_r[k] <= '0;
      end
    end else begin
      case (st)
        ST_OP: if (take) begin
          opc_r     <= in_byte;
          len_r     <= LEN_W'(1);
          idx       <= '0;
          nspec_r   <= '0;
          need_base <= 1'b0;
          trap_r    <= info.trap;
          illop_r   <= !info.legal;
          illspec_r <= 1'b0;
          br_r      <= '0;
          brlen_r   <= info.brlen;
          ops_left  <= info.nops;
          nops_r    <= (info.legal && !info.trap) ? info.nops : '0;
          dtot      <= info.brlen;
          disp_left <= info.brlen;
          pos       <= '0;
          acc       <= '0;
          for (int k = 0; k < MAX_SPEC; k++) begin
            spec_r[k] <= '0;
            disp_r[k] <= '0;
          end
          if (!info.legal || info.trap) st <= ST_OUT;
          else if (info.nops != '0)     st <= ST_SPEC;
          else if (info.brlen != '0)    st <= ST_BR;
          else                          st <= ST_OUT;
        end
        ST_SPEC: if (take) begin
          spec_r[slot] <= in_byte;
          len_r        <= len_r + LEN_W'(1);
          nspec_r      <= idx + CNT_W'(1);
          if (bad_base) begin
            illspec_r <= 1'b1;
            st        <= ST_OUT;
          end else if (c_idx) begin
            need_base <= 1'b1;
            idx       <= idx + CNT_W'(1);
          end else if (c_dlen != '0) begin
            need_base <= 1'b0;
            disp_left <= c_dlen;
            dtot      <= c_dlen;
            pos       <= '0;
            acc       <= '0;
            st        <= ST_DISP;
          end else begin
            need_base <= 1'b0;
            idx       <= idx + CNT_W'(1);
            ops_left  <= ops_left - NOPS_W'(1);
            st        <= fin_st;
            disp_left <= brlen_r;
            dtot      <= brlen_r;
            pos       <= '0;
            acc       <= '0;
          end
        end
        ST_DISP: if (take) begin
          len_r <= len_r + LEN_W'(1);
          if (disp_left == 3'd1) begin
            disp_r[slot] <= dval;
            idx          <= idx + CNT_W'(1);
            ops_left     <= ops_left - NOPS_W'(1);
            st           <= fin_st;
            disp_left    <= brlen_r;
            dtot         <= brlen_r;
            pos          <= '0;
            acc          <= '0;
          end else begin
            acc       <= acc_nxt;
            pos       <= pos + 2'd1;
            disp_left <= disp_left - 3'd1;
          end
        end
        ST_BR: if (take) begin
          len_r <= len_r + LEN_W'(1);
          if (disp_left == 3'd1) begin
            br_r <= dval;
            st   <= ST_OUT;
          end else begin
            acc       <= acc_nxt;
            pos       <= pos + 2'd1;
            disp_left <= disp_left - 3'd1;
          end
        end
        ST_OUT: if (out_ready) st <= ST_OP;
        default: st <= ST_OP;
      endcase
    end
  end

  for (genvar k = 0; k < MAX_SPEC; k++) begin : g_slot
    assign out_spec[8*k +: 8]           = spec_r[k];
    assign out_disp[DISP_W*k +: DISP_W] = disp_r[k];
  end

  assign out_valid   = (st == ST_OUT);
  assign out_opcode  = opc_r;
  assign out_nops    = nops_r;
  assign out_nspec   = nspec_r;
  assign out_br_disp = br_r;
  assign out_len     = len_r;
  assign out_trap    = trap_r;
  assign out_illop   = illop_r;
  assign out_illspec = illspec_r;

endmodule

// File: rtl/vlp_parser_chk.sv
module vlp_parser_chk #(
  parameter int CNT_W = 4,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_opcode,
  input logic [CNT_W-1:0] out_nspec,
  input logic [LEN_W-1:0] out_len,
  input logic             out_trap,
  input logic             out_illop,
  input logic             out_illspec
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R1

  AST_NO_TAKE_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R2

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_opcode)
                                   && $stable(out_nspec))); // R2

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid); // R2

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_trap, out_illop, out_illspec}) <= 1)); // R12

  AST_TRAP_SHORT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trap) |-> (out_len == LEN_W'(1) && out_nspec == '0)); // R9

  AST_ILLOP_SHORT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illop) |-> (out_len == LEN_W'(1) && out_nspec == '0)); // R10

  AST_ABORT_SLOT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illspec) |-> (out_nspec >= CNT_W'(2))); // R8

endmodule

bind vlp_parser vlp_parser_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_opcode(out_opcode), .out_nspec(out_nspec),
  .out_len(out_len), .out_trap(out_trap), .out_illop(out_illop),
  .out_illspec(out_illspec)
);

// File: tb/tb_vlp_parser.sv
`timescale 1ns/1ps
module tb_vlp_parser;

  localparam int MAX_OPS  = 4;
  localparam int MAX_SPEC = 2 * MAX_OPS;
  localparam int CNT_W    = $clog2(MAX_SPEC + 1);
  localparam int LEN_W    = $clog2(MAX_SPEC + 4 * MAX_OPS + 6);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_opcode;
  logic [2:0] out_nops;
  logic [CNT_W-1:0] out_nspec;
  logic [8*MAX_SPEC-1:0] out_spec;
  logic [32*MAX_SPEC-1:0] out_disp;
  logic [31:0] out_br_disp;
  logic [LEN_W-1:0] out_len;
  logic out_trap, out_illop, out_illspec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vlp_parser #(.MAX_OPS(MAX_OPS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_nops(out_nops), .out_nspec(out_nspec), .out_spec(out_spec), .out_disp(out_disp),
    .out_br_disp(out_br_disp), .out_len(out_len), .out_trap(out_trap),
    .out_illop(out_illop), .out_illspec(out_illspec)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_byte  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rec(input string tag, input logic [7:0] op, input int nops, input int nspec,
                     input int len, input bit trap, input bit illop, input bit illspec);
    while (!out_valid) @(negedge clk);
    ck({tag, " opcode"},  32'(out_opcode), 32'(op));
    ck({tag, " nops"},    32'(out_nops), 32'(nops));
    ck({tag, " nspec"},   32'(out_nspec), 32'(nspec));
    ck({tag, " len"},     32'(out_len), 32'(len));
    ck({tag, " flags"},   {29'd0, out_trap, out_illop, out_illspec}, {29'd0, trap, illop, illspec});
  endtask

  function automatic logic [7:0] spec_at(input int k);
    return out_spec[8*k +: 8];
  endfunction

  function automatic logic [31:0] disp_at(input int k);
    return out_disp[32*k +: 32];
  endfunction

  task automatic release_rec(input string tag);
    logic [LEN_W-1:0] l0;
    l0 = out_len;
    ck({tag, " R2 in_ready low while pending"}, 32'(in_ready), 32'd0);
    @(negedge clk);
    ck({tag, " R2 record held"}, {31'd0, out_valid}, 32'd1);
    ck({tag, " R2 length stable"}, 32'(out_len), 32'(l0));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    ck({tag, " R2 released"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    ck("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    ck("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_nop();
    send(8'h10);
    rec("R3 nop", 8'h10, 0, 0, 1, 0, 0, 0);
    release_rec("R3");
  endtask

  task automatic t_two_ops();
    send(8'h09); send(8'h51); send(8'h23);
    rec("R4 two operands", 8'h09, 2, 2, 3, 0, 0, 0);
    ck("R5 R12 slot0 register spec", 32'(spec_at(0)), 32'h51);
    ck("R5 R12 slot1 literal spec", 32'(spec_at(1)), 32'h23);
    ck("R5 literal has no displacement", disp_at(1), 32'h0);
    release_rec("R4");
  endtask

  task automatic t_disp_widths();
    send(8'h18);
    send(8'hA2); send(8'h80);
    send(8'hC3); send(8'h34); send(8'h12);
    send(8'hE4); send(8'h78); send(8'h56); send(8'h34); send(8'h12);
    rec("R6 three operands", 8'h18, 3, 3, 11, 0, 0, 0);
    ck("R6 byte disp sign-extended", disp_at(0), 32'hFFFFFF80);
    ck("R6 word disp little-endian", disp_at(1), 32'h00001234);
    ck("R6 long disp little-endian", disp_at(2), 32'h12345678);
    ck("R12 slot2 spec", 32'(spec_at(2)), 32'hE4);
    release_rec("R6");
    send(8'h09); send(8'hD1); send(8'hFF); send(8'hFF); send(8'h60);
    rec("R6 negative word", 8'h09, 2, 2, 5, 0, 0, 0);
    ck("R6 word disp -1", disp_at(0), 32'hFFFFFFFF);
    release_rec("R6b");
  endtask

  task automatic t_index();
    send(8'h2E);
    send(8'h41); send(8'h62);
    send(8'h00);
    send(8'h85);
    send(8'hD7); send(8'hFE); send(8'hFF);
    rec("R7 indexed four operands", 8'h2E, 4, 5, 8, 0, 0, 0);
    ck("R7 slot0 index prefix", 32'(spec_at(0)), 32'h41);
    ck("R7 slot1 base", 32'(spec_at(1)), 32'h62);
    ck("R7 slot3 autoinc", 32'(spec_at(3)), 32'h85);
    ck("R7 slot4 disp", disp_at(4), 32'hFFFFFFFE);
    release_rec("R7");
    send(8'h3E); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    rec("R4 ediv four literals", 8'h3E, 4, 4, 5, 0, 0, 0);
    release_rec("R4b");
  endtask

  task automatic t_bad_base();
    send(8'h09); send(8'h43); send(8'h52);
    rec("R8 register after index", 8'h09, 2, 2, 3, 0, 0, 1);
    ck("R8 offending byte kept", 32'(spec_at(1)), 32'h52);
    release_rec("R8");
    send(8'h09); send(8'h41); send(8'h42);
    rec("R8 index after index", 8'h09, 2, 2, 3, 0, 0, 1);
    release_rec("R8b");
    send(8'h09); send(8'h41); send(8'h1F);
    rec("R8 literal after index", 8'h09, 2, 2, 3, 0, 0, 1);
    release_rec("R8c");
    send(8'h10);
    rec("R8 resync to opcode", 8'h10, 0, 0, 1, 0, 0, 0);
    release_rec("R8d");
  endtask

  task automatic t_trap();
    logic [7:0] tl [4];
    tl = '{8'h05, 8'hC6, 8'h97, 8'hF7};
    foreach (tl[i]) begin
      send(tl[i]);
      rec("R9 emulation trap", tl[i], 0, 0, 1, 1, 0, 0);
      release_rec("R9");
    end
  endtask

  task automatic t_illegal();
    logic [7:0] il [3];
    il = '{8'h02, 8'hFF, 8'h04};
    foreach (il[i]) begin
      send(il[i]);
      rec("R10 unused opcode", il[i], 0, 0, 1, 0, 1, 0);
      release_rec("R10");
    end
    send(8'h10);
    rec("R10 next byte is opcode", 8'h10, 0, 0, 1, 0, 0, 0);
    release_rec("R10b");
  endtask

  task automatic t_branch();
    send(8'h11); send(8'h80);
    rec("R11 byte branch", 8'h11, 0, 0, 2, 0, 0, 0);
    ck("R11 byte branch value", out_br_disp, 32'hFFFFFF80);
    release_rec("R11");
    send(8'h13); send(8'h34); send(8'h12);
    rec("R11 word branch", 8'h13, 0, 0, 3, 0, 0, 0);
    ck("R11 word branch value", out_br_disp, 32'h00001234);
    release_rec("R11b");
    send(8'h0E); send(8'h51); send(8'h02); send(8'hFE); send(8'hFF);
    rec("R11 operands then branch", 8'h0E, 2, 2, 5, 0, 0, 0);
    ck("R11 bit-branch value", out_br_disp, 32'hFFFFFFFE);
    release_rec("R11c");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nop();
    t_two_ops();
    t_disp_widths();
    t_index();
    t_bad_base();
    t_trap();
    t_illegal();
    t_branch();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule